// File: doc/BRIEF.md
# Dirty Band Update Coalescer

The block walks a frame from top to bottom in horizontal bands four display rows tall and asks, one band per cycle, whether that band has been marked dirty since the last refresh. It does not send one update for each dirty band. It joins every run of adjacent dirty bands into a single full-width rectangle that starts at row zero of the run and covers all of its rows. Each rectangle goes out on a valid/ready descriptor stream.

During the walk the block keeps track of the lowest and highest dirty band indices. When the walk ends it issues one clear request covering that whole inclusive range, so the owner of the dirty bits can reset them in a single operation. A done pulse marks the end of each pass.

A display refresh engine uses the block by giving it the frame height and a start pulse. It answers the band lookups from its dirty-bit store in the same cycle, without registering them. It then takes the rectangles and the clear request.

Top module: `dirty_band_coalescer`

## Requirements
- R1: After reset the block is idle: `busy`, `rect_valid`, `clr_valid` and `done` are all low.
- R2: A pass looks up band indices 0, 1, 2, … in turn, and band n covers rows 4n to 4n+3. The pass stops at the first band whose first row is not below the frame height latched at start, so a height that is not a multiple of four is rounded up to whole bands. A height of zero looks up no band.
- R3: A run opens at a dirty band found while no run is open. The rectangle for that run reports `rect_y` equal to four times the index of that band.
- R4: When a clean band follows an open run, the block emits one descriptor with `rect_x` = 0, `rect_w` = FRAME_W, and `rect_h` = 4 × (number of dirty bands in the run). The run then closes.
- R5: A run that is still open when the pass stops is emitted as a final descriptor. Its `rect_h` is the row where the pass stopped minus `rect_y`.
- R6: After a pass with at least one dirty band, `clr_valid` is high for exactly one cycle. During that cycle `clr_lo` and `clr_hi` hold the lowest and highest dirty band indices of the pass.
- R7: A pass with no dirty band raises no `clr_valid` and emits no descriptor.
- R8: While `rect_valid` is high and `rect_ready` is low, the descriptor stays unchanged and the pass does not advance. No descriptor is lost or repeated.
- R9: `done` is high for one cycle. It comes in the cycle after `clr_valid`, or, when nothing was dirty, in the cycle after the pass stops.
- R10: A `start` pulse that arrives while `busy` is high has no effect on the pass in progress or on its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a pass when idle |
| frame_height | input | ROW_W | Frame height in rows, latched at start |
| busy | output | 1 | A pass is in progress |
| band_idx | output | ROW_W-2 | Band being looked up |
| band_dirty | input | 1 | Dirty bit of `band_idx`, same cycle |
| rect_valid | output | 1 | Descriptor available |
| rect_ready | input | 1 | Consumer accepts descriptor |
| rect_x | output | X_W | Left column of rectangle (always 0) |
| rect_w | output | X_W+1 | Rectangle width (FRAME_W) |
| rect_y | output | ROW_W | First row of rectangle |
| rect_h | output | ROW_W+1 | Row count of rectangle |
| clr_valid | output | 1 | One-cycle clear-range request |
| clr_lo | output | ROW_W-2 | First band to clear |
| clr_hi | output | ROW_W-2 | Last band to clear, inclusive |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The hardest case to reach is a run whose descriptor stalls under backpressure while the next bands are still waiting to be scanned. The bench reaches it by driving `rect_ready` from a sparse random process across a 100-band frame with many short runs. A scoreboard then shows that the stalled descriptor neither changes nor skips a band. A second start pulse is injected mid-pass, together with a changed height on the input, to show that it is ignored. Frames with a height that is not a multiple of four, and frames whose last band is dirty, exercise the final-run flush.

// File: rtl/dirty_band_coalescer.sv
module dirty_band_coalescer #(
  parameter int ROW_W   = 12,
  parameter int X_W     = 11,
  parameter int FRAME_W = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ROW_W-1:0]   frame_height,
  output logic               busy,
  output logic [ROW_W-3:0]   band_idx,
  input  logic               band_dirty,
  output logic               rect_valid,
  input  logic               rect_ready,
  output logic [X_W-1:0]     rect_x,
  output logic [X_W:0]       rect_w,
  output logic [ROW_W-1:0]   rect_y,
  output logic [ROW_W:0]     rect_h,
  output logic               clr_valid,
  output logic [ROW_W-3:0]   clr_lo,
  output logic [ROW_W-3:0]   clr_hi,
  output logic               done
);
  localparam int BAND_W = ROW_W - 2;
  localparam int STEP   = 4;

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_EMIT, S_FIN, S_DONE} state_t;

  state_t             st;
  logic [ROW_W-1:0]   height_q;
  logic [ROW_W:0]     row_q;
  logic [ROW_W-1:0]   run_y;
  logic               open_q;
  logic               last_q;
  logic [BAND_W-1:0]  min_q, max_q;
  logic               scan_end;
  logic [ROW_W:0]     run_h;

  assign busy      = (st != S_IDLE);
  assign band_idx  = row_q[BAND_W+1:2];
  assign scan_end  = row_q >= {1'b0, height_q};
  assign run_h     = row_q - {1'b0, run_y};
  assign rect_x    = '0;
  assign rect_w    = (X_W+1)'(FRAME_W);
  assign rect_valid = (st == S_EMIT);
  assign clr_valid = (st == S_FIN) && (max_q >= min_q);
  assign clr_lo    = min_q;
  assign clr_hi    = max_q;
  assign done      = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      height_q <= '0;
      row_q    <= '0;
      run_y    <= '0;
      open_q   <= 1'b0;
      last_q   <= 1'b0;
      min_q    <= '1;
      max_q    <= '0;
      rect_y   <= '0;
      rect_h   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_SCAN;
          height_q <= frame_height;
          row_q    <= '0;
          open_q   <= 1'b0;
          last_q   <= 1'b0;
          min_q    <= '1;
          max_q    <= '0;
        end
        S_SCAN: begin
          if (scan_end) begin
            if (open_q) begin
              rect_y <= run_y;
              rect_h <= run_h;
              open_q <= 1'b0;
              last_q <= 1'b1;
              st     <= S_EMIT;
            end else begin
              st <= S_FIN;
            end
          end else if (band_dirty) begin
            if (!open_q) begin
              open_q <= 1'b1;
              run_y  <= row_q[ROW_W-1:0];
            end
            if (band_idx < min_q) min_q <= band_idx;
            if (band_idx > max_q) max_q <= band_idx;
            row_q <= row_q + (ROW_W+1)'(STEP);
          end else begin
            if (open_q) begin
              rect_y <= run_y;
              rect_h <= run_h;
              open_q <= 1'b0;
              st     <= S_EMIT;
            end
            row_q <= row_q + (ROW_W+1)'(STEP);
          end
        end
        S_EMIT: if (rect_ready) st <= last_q ? S_FIN : S_SCAN;
        S_FIN:  st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dirty_band_coalescer_chk #(
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             start,
  input logic             rect_valid,
  input logic             rect_ready,
  input logic [ROW_W-1:0] rect_y,
  input logic [ROW_W:0]   rect_h,
  input logic             clr_valid,
  input logic [ROW_W-3:0] clr_lo,
  input logic [ROW_W-3:0] clr_hi,
  input logic             done
);
  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rect_valid && !rect_ready |=> rect_valid && $stable(rect_y) && $stable(rect_h));
  // R4
  rect_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rect_valid |-> rect_h != '0 && rect_h[1:0] == 2'b00 && rect_y[1:0] == 2'b00);
  // R6
  clr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> clr_lo <= clr_hi);
  // R6
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> !clr_valid);
  // R9
  done_after_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> done);
  // R9
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !done);
  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !done |=> busy);
endmodule

bind dirty_band_coalescer dirty_band_coalescer_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start(start),
  .rect_valid(rect_valid), .rect_ready(rect_ready), .rect_y(rect_y),
  .rect_h(rect_h), .clr_valid(clr_valid), .clr_lo(clr_lo), .clr_hi(clr_hi),
  .done(done)
);

// File: tb/dirty_band_coalescer_tb.sv
module dirty_band_coalescer_tb;
  localparam int ROW_W = 12;
  localparam int X_W = 11;
  localparam int FRAME_W = 1024;
  localparam int NB = 1 << (ROW_W - 2);

  logic clk = 0, rst_n = 0, start = 0, rect_ready = 1, band_dirty;
  logic [ROW_W-1:0] frame_height = '0;
  logic busy, rect_valid, clr_valid, done;
  logic [ROW_W-3:0] band_idx, clr_lo, clr_hi;
  logic [X_W-1:0] rect_x;
  logic [X_W:0] rect_w;
  logic [ROW_W-1:0] rect_y;
  logic [ROW_W:0] rect_h;

  logic dirty_mem [0:NB-1];
  assign band_dirty = dirty_mem[band_idx];

  int n_chk = 0, n_fail = 0, cyc = 0, rdy_mode = 0;
  int exp_y[$], exp_h[$];
  int exp_lo, exp_hi;
  bit exp_clr;
  int clr_seen, clr_cyc;
  bit prev_stall = 0;
  int prev_y, prev_h;

  dirty_band_coalescer #(.ROW_W(ROW_W), .X_W(X_W), .FRAME_W(FRAME_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_height(frame_height),
    .busy(busy), .band_idx(band_idx), .band_dirty(band_dirty),
    .rect_valid(rect_valid), .rect_ready(rect_ready), .rect_x(rect_x),
    .rect_w(rect_w), .rect_y(rect_y), .rect_h(rect_h), .clr_valid(clr_valid),
    .clr_lo(clr_lo), .clr_hi(clr_hi), .done(done));

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  initial forever begin
    @(posedge clk); #1;
    rect_ready = (rdy_mode == 0) ? 1'b1 : ($urandom % 4 == 0);
  end

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (prev_stall) begin
      check(rect_valid && rect_y == prev_y && rect_h == prev_h, "R8 stall hold", rect_y, prev_y);
    end
    prev_stall = rect_valid && !rect_ready;
    prev_y = rect_y; prev_h = rect_h;
    if (rect_valid && rect_ready) begin
      if (exp_y.size() == 0) begin
        check(0, "R7 unexpected rect", rect_y, -1);
      end else begin
        int ey, eh;
        ey = exp_y.pop_front(); eh = exp_h.pop_front();
        check(rect_y == ey, "R3 rect_y", rect_y, ey);
        check(rect_h == eh, "R4/R5 rect_h", rect_h, eh);
        check(rect_x == 0 && rect_w == FRAME_W, "R4 x/w", rect_w, FRAME_W);
      end
    end
    if (clr_valid) begin
      clr_seen++; clr_cyc = cyc;
      check(exp_clr, "R7 unexpected clear", 1, 0);
      check(clr_lo == exp_lo, "R6 clr_lo", clr_lo, exp_lo);
      check(clr_hi == exp_hi, "R6 clr_hi", clr_hi, exp_hi);
    end
  end

  task automatic expect_pass(input int h);
    int ys = -1, mn = NB, mx = -1, y;
    for (y = 0; y < h; y += 4) begin
      if (dirty_mem[y/4]) begin
        if (ys < 0) ys = y;
        if (y/4 < mn) mn = y/4;
        if (y/4 > mx) mx = y/4;
      end else if (ys >= 0) begin
        exp_y.push_back(ys); exp_h.push_back(y - ys); ys = -1;
      end
    end
    if (ys >= 0) begin exp_y.push_back(ys); exp_h.push_back(y - ys); end
    exp_clr = (mx >= 0); exp_lo = mn; exp_hi = mx;
    clr_seen = 0; clr_cyc = -10;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < NB; i++) dirty_mem[i] = 1'b0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic run_pass(input int h, input bit restart, input string tag);
    frame_height = h[ROW_W-1:0];
    expect_pass(h);
    pulse_start();
    if (restart) begin
      repeat (5) @(posedge clk);
      #1 frame_height = 8; start = 1;
      @(posedge clk); #1 start = 0;
      check(busy, "R10 busy kept", busy, 1);
    end
    do @(negedge clk); while (!done);
    check(exp_y.size() == 0, {tag, " all rects seen"}, exp_y.size(), 0);
    check(clr_seen == (exp_clr ? 1 : 0), {tag, " R6/R7 clear count"}, clr_seen, exp_clr);
    if (exp_clr) check(clr_cyc == cyc - 1, "R9 done after clear", cyc - clr_cyc, 1);
    @(negedge clk);
    check(!done && !busy, "R9 done single", done, 0);
    exp_y.delete(); exp_h.delete();
  endtask

  initial begin
    clear_mem();
    #1;
    check(!busy && !rect_valid && !clr_valid && !done, "R1 reset idle", busy, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!busy && !rect_valid && !clr_valid && !done, "R1 after reset", busy, 0);

    // R2 R3 R4 several runs, ready high
    clear_mem();
    dirty_mem[1] = 1; dirty_mem[2] = 1; dirty_mem[3] = 1;
    dirty_mem[7] = 1; dirty_mem[10] = 1; dirty_mem[11] = 1;
    dirty_mem[20] = 1;
    run_pass(64, 0, "R4 runs");

    // R5 trailing run, height not a multiple of 4
    clear_mem();
    dirty_mem[5] = 1; dirty_mem[6] = 1; dirty_mem[7] = 1;
    run_pass(30, 0, "R5 tail");

    // R7 nothing dirty (band 12 beyond height)
    clear_mem();
    dirty_mem[12] = 1;
    run_pass(40, 0, "R7 clean");

    // R2 zero height
    run_pass(0, 0, "R2 zero height");

    // whole frame dirty
    clear_mem();
    for (int i = 0; i < 4; i++) dirty_mem[i] = 1;
    run_pass(16, 0, "R5 full");

    // R8 backpressure, random pattern
    rdy_mode = 1;
    clear_mem();
    for (int i = 0; i < 100; i++) dirty_mem[i] = ($urandom % 3 == 0);
    dirty_mem[99] = 1;
    run_pass(400, 0, "R8 backpressure");
    clear_mem();
    for (int i = 0; i < 100; i++) dirty_mem[i] = ($urandom % 2 == 0);
    run_pass(397, 0, "R8 backpressure 2");
    rdy_mode = 0;

    // R10 start during pass
    clear_mem();
    dirty_mem[2] = 1; dirty_mem[9] = 1; dirty_mem[10] = 1;
    run_pass(60, 1, "R10 restart");

    finish_run();
  end
endmodule